// File: doc/BRIEF.md
# Five-Line SPI Master Access Sequencer

This block is the master-side access controller for an SPI link that has a fifth line. Besides MOSI, MISO, a serial clock and an active-low select, the slave has an active-high request line that it pulses when it wants to exchange data. An access starts in one of two ways. The host can pulse a start input, or the block can see the rising edge of the slave request. In both cases the block drives select low, holds off for a programmable slave-ready wait, and clocks a programmable number of bytes in mode 0, most significant bit first. It holds select for half a clock period after the last falling edge, releases it, and reports completion.

The wait is taken from one of two registers. The normal ready time is used by default, and a longer resume time is used when the host marks the slave as sleeping. A host-started access can skip the wait altogether, for example on the very first access after power-up. A start that arrives while an access is running is held and served afterwards. When the bus is disabled, the block floats MOSI and select and holds the clock low. Bytes come from the host one at a time through `tx_data`/`tx_take`, and each received byte is reported on `rx_data`/`rx_valid`.

Top module: `spi5m_mac_seq`

## Requirements
- R1: While reset is applied, MOSI and select are undriven (`mosi_oe`=0, `nss_oe`=0), `sclk`=0 and `busy`=0. With `bus_enable` high after reset, select is driven high (`nss_oe`=1, `nss_o`=1) with no access.
- R2: A one-cycle `host_start` pulse drives select low. The first rising clock edge comes exactly T+1+HALF system cycles after select falls, where T is `t1_cycles` and HALF is the clock half-period parameter (default 2).
- R3: When `slave_sleeping` is 1 at the start of an access, T is `t3_cycles` instead of `t1_cycles`.
- R4: When `skip_wait` is 1 for a host-started access, T is 0.
- R5: A rising edge on `slave_irq` while idle starts one access with T = `t1_cycles`. Holding `slave_irq` high afterwards starts no further access.
- R6: When `host_start` and a `slave_irq` rising edge arrive together, exactly one access runs and it follows the host rules, including `skip_wait`. Any request edge seen while an access is running is absorbed by that access.
- R7: Mode 0 clocking. `sclk` idles low and each high and low phase lasts HALF cycles. An access gives exactly 8·`byte_count` rising edges. Byte k of `tx_data` is shifted out MSB first. The byte sampled from MISO on rising edges is presented on `rx_data` with a one-cycle `rx_valid`.
- R8: Select stays low for exactly HALF system cycles after the last falling clock edge and is then released high.
- R9: `bus_enable` low takes effect once the block is idle; an access already running completes first. While disabled, MOSI and select are undriven, `sclk`=0, and host starts and request edges are ignored.
- R10: `busy` is high from the cycle after an access starts until select is released. `done` pulses for one cycle as select returns high. A `host_start` arriving while busy is held and starts a second access after the first one ends.
- R11: A `byte_count` of 0 gives a select pulse with no clock edges, followed by `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_enable | input | 1 | 1 = bus active, 0 = deactivate and float lines |
| host_start | input | 1 | One-cycle request for an access |
| skip_wait | input | 1 | Host access without ready wait |
| slave_sleeping | input | 1 | Use resume time instead of ready time |
| t1_cycles | input | TW | Ready wait in system cycles |
| t3_cycles | input | TW | Resume wait in system cycles |
| byte_count | input | CNT_W | Bytes per access |
| tx_data | input | BYTE_W | Next byte to send |
| tx_take | output | 1 | Pulses once after `tx_data` was captured |
| rx_data | output | BYTE_W | Last received byte |
| rx_valid | output | 1 | `rx_data` updated |
| slave_irq | input | 1 | Active-high slave request (asynchronous) |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to slave |
| mosi_oe | output | 1 | MOSI output enable |
| nss_o | output | 1 | Select level, active low |
| nss_oe | output | 1 | Select output enable |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access finished (one cycle) |

## Verification
Several properties are checked on every cycle: the clock only toggles while select is driven low, select only rises with the clock low, and no rising edge comes before the latched wait has elapsed. The count of rising edges per access must match the latched byte count, `done` must coincide with the release of select, and outputs may only go undriven from idle with the bus disabled. The bench scenarios are the only means of showing the exact wait-to-first-edge delays of each path, the data content in both directions, the merging of simultaneous requests, the queuing of a second host start, and the ignoring of requests while the bus is down.

// File: rtl/spi5m_pkg.sv
package spi5m_pkg;
   typedef enum logic [2:0] {
      ST_OFF,
      ST_IDLE,
      ST_WAIT,
      ST_XFER,
      ST_HOLD
   } seq_state_t;
endpackage

// File: rtl/spi5m_edge_sync.sv
module spi5m_edge_sync #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (SYNC < 2) begin : g_bad_sync
      $error("spi5m_edge_sync: SYNC must be at least 2");
   end

   logic [SYNC-1:0] sync_q;
   logic            prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b0;
      else        sync_q[0] <= async_in;
   end

   for (genvar i = 1; i < SYNC; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b0;
         else        sync_q[i] <= sync_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC-1];
   end

   assign rise_o = sync_q[SYNC-1] & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R5
endmodule

// File: rtl/spi5m_shifter.sv
module spi5m_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         rise,
   input  logic         fall,
   input  logic         miso,
   input  logic [W-1:0] tx_data,
   output logic         mosi,
   output logic [W-1:0] rx_data,
   output logic         rx_valid,
   output logic         last_bit
);
   if (W < 2) begin : g_bad_w
      $error("spi5m_shifter: W must be at least 2");
   end

   localparam int BIT_W = $clog2(W);

   logic [W-1:0]     tx_sh;
   logic [W-1:0]     rx_sh;
   logic [BIT_W-1:0] bit_idx;

   assign last_bit = (bit_idx == BIT_W'(W-1));
   assign mosi     = tx_sh[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh    <= '0;
         rx_sh    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         bit_idx  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (rise) begin
            rx_sh <= {rx_sh[W-2:0], miso};
            if (last_bit) begin
               rx_data  <= {rx_sh[W-2:0], miso};
               rx_valid <= 1'b1;
            end
         end
         if (load) begin
            tx_sh   <= tx_data;
            bit_idx <= '0;
         end else if (fall) begin
            if (last_bit) begin
               bit_idx <= '0;
            end else begin
               tx_sh   <= {tx_sh[W-2:0], 1'b0};
               bit_idx <= bit_idx + BIT_W'(1);
            end
         end
      end
   end

   AST_RX_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(rise)); // R7
   AST_LOAD_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (bit_idx == '0) || (fall && last_bit)); // R7
endmodule

// File: rtl/spi5m_mac_seq.sv
module spi5m_mac_seq
   import spi5m_pkg::*;
#(
   parameter int HALF   = 2,
   parameter int TW     = 16,
   parameter int CNT_W  = 8,
   parameter int BYTE_W = 8,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_enable,
   input  logic              host_start,
   input  logic              skip_wait,
   input  logic              slave_sleeping,
   input  logic [TW-1:0]     t1_cycles,
   input  logic [TW-1:0]     t3_cycles,
   input  logic [CNT_W-1:0]  byte_count,
   input  logic [BYTE_W-1:0] tx_data,
   output logic              tx_take,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              slave_irq,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   output logic              nss_o,
   output logic              nss_oe,
   output logic              busy,
   output logic              done
);
   if (HALF < 1) begin : g_bad_half
      $error("spi5m_mac_seq: HALF must be at least 1");
   end
   if (TW < 1 || CNT_W < 1) begin : g_bad_width
      $error("spi5m_mac_seq: TW and CNT_W must be positive");
   end

   localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int SEL_W = TW + PH_W + 2;
   localparam int RC_W  = CNT_W + $clog2(BYTE_W) + 1;

   seq_state_t        st;
   logic [TW-1:0]     wcnt;
   logic [TW-1:0]     wait_lat;
   logic [PH_W-1:0]   ph;
   logic [CNT_W-1:0]  left;
   logic [CNT_W-1:0]  bytes_lat;
   logic              host_pend;
   logic              sclk_r;
   logic              nss_r;
   logic              done_r;
   logic              take_r;
   logic              irq_rise;
   logic              last_bit;
   logic              go_host;
   logic              tick;
   logic              rise_s;
   logic              fall_s;
   logic              wait_end;
   logic              load;
   logic [TW-1:0]     wait_sel;

   spi5m_edge_sync #(.SYNC(SYNC)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (slave_irq),
      .rise_o   (irq_rise)
   );

   assign go_host  = host_start | host_pend;
   assign wait_sel = (go_host && skip_wait) ? '0
                   : (slave_sleeping ? t3_cycles : t1_cycles);
   assign tick     = (ph == PH_W'(HALF-1));
   assign rise_s   = (st == ST_XFER) && tick && !sclk_r;
   assign fall_s   = (st == ST_XFER) && tick && sclk_r;
   assign wait_end = (st == ST_WAIT) && (wcnt == '0);
   assign load     = (wait_end && left != '0)
                   || (fall_s && last_bit && left != CNT_W'(1));

   spi5m_shifter #(.W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .rise     (rise_s),
      .fall     (fall_s),
      .miso     (miso),
      .tx_data  (tx_data),
      .mosi     (mosi),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .last_bit (last_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_OFF;
         wcnt      <= '0;
         wait_lat  <= '0;
         ph        <= '0;
         left      <= '0;
         bytes_lat <= '0;
         host_pend <= 1'b0;
         sclk_r    <= 1'b0;
         nss_r     <= 1'b1;
         done_r    <= 1'b0;
         take_r    <= 1'b0;
      end else begin
         done_r <= 1'b0;
         take_r <= load;
         if (host_start && (st == ST_WAIT || st == ST_XFER || st == ST_HOLD))
            host_pend <= 1'b1;
         case (st)
            ST_OFF: begin
               host_pend <= 1'b0;
               if (bus_enable) st <= ST_IDLE;
            end
            ST_IDLE: begin
               if (!bus_enable) begin
                  st        <= ST_OFF;
                  host_pend <= 1'b0;
               end else if (go_host || irq_rise) begin
                  st        <= ST_WAIT;
                  nss_r     <= 1'b0;
                  wcnt      <= wait_sel;
                  wait_lat  <= wait_sel;
                  left      <= byte_count;
                  bytes_lat <= byte_count;
                  host_pend <= 1'b0;
               end
            end
            ST_WAIT: begin
               if (wcnt == '0) begin
                  ph <= '0;
                  st <= (left == '0) ? ST_HOLD : ST_XFER;
               end else begin
                  wcnt <= wcnt - TW'(1);
               end
            end
            ST_XFER: begin
               if (tick) begin
                  ph     <= '0;
                  sclk_r <= ~sclk_r;
                  if (sclk_r && last_bit) begin
                     if (left == CNT_W'(1)) st <= ST_HOLD;
                     else                   left <= left - CNT_W'(1);
                  end
               end else begin
                  ph <= ph + PH_W'(1);
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  ph     <= '0;
                  nss_r  <= 1'b1;
                  done_r <= 1'b1;
                  st     <= ST_IDLE;
               end else begin
                  ph <= ph + PH_W'(1);
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end

   assign sclk    = sclk_r;
   assign nss_o   = nss_r;
   assign nss_oe  = (st != ST_OFF);
   assign mosi_oe = (st != ST_OFF);
   assign busy    = (st == ST_WAIT) || (st == ST_XFER) || (st == ST_HOLD);
   assign done    = done_r;
   assign tx_take = take_r;

   // Cycle counters used only by the properties below
   logic [SEL_W-1:0] sel_cyc;
   logic [RC_W-1:0]  rise_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_cyc  <= '0;
         rise_cnt <= '0;
      end else begin
         if (nss_r)                sel_cyc <= '0;
         else if (sel_cyc != '1)   sel_cyc <= sel_cyc + SEL_W'(1);
         if (nss_r)                rise_cnt <= '0;
         else if (rise_s)          rise_cnt <= rise_cnt + RC_W'(1);
      end
   end

   AST_CLK_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (!nss_o && nss_oe)); // R2
   AST_WAIT_BEFORE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (32'(sel_cyc) > 32'(wait_lat))); // R3
   AST_RELEASE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nss_o) |-> (!sclk && !$past(sclk))); // R8
   AST_EDGE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nss_o) |-> (32'(rise_cnt) == 32'(bytes_lat) * BYTE_W)); // R7
   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($rose(nss_o) && !busy)); // R10
   AST_FLOAT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nss_oe) |-> (!$past(busy) && !$past(bus_enable))); // R9
endmodule

// File: tb/spi5m_mac_seq_tb.sv
module spi5m_mac_seq_tb;
   localparam int HALF = 2;
   localparam int T1   = 10;
   localparam int T3   = 25;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_enable = 1'b0;
   logic       host_start = 1'b0;
   logic       skip_wait = 1'b0;
   logic       slave_sleeping = 1'b0;
   logic [15:0] t1_cycles = 16'(T1);
   logic [15:0] t3_cycles = 16'(T3);
   logic [7:0] byte_count = 8'd1;
   logic [7:0] tx_data;
   logic       tx_take;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       slave_irq = 1'b0;
   logic       miso;
   logic       sclk, mosi, mosi_oe, nss_o, nss_oe, busy, done;

   always #5 clk = ~clk;

   spi5m_mac_seq #(.HALF(HALF)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_enable(bus_enable), .host_start(host_start),
      .skip_wait(skip_wait), .slave_sleeping(slave_sleeping),
      .t1_cycles(t1_cycles), .t3_cycles(t3_cycles), .byte_count(byte_count),
      .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
      .slave_irq(slave_irq), .miso(miso), .sclk(sclk), .mosi(mosi),
      .mosi_oe(mosi_oe), .nss_o(nss_o), .nss_oe(nss_oe), .busy(busy), .done(done)
   );

   function automatic logic [7:0] m_byte(input int k);
      return 8'h5A + 8'(k) * 8'h1D;
   endfunction
   function automatic logic [7:0] s_byte(input int k);
      return 8'hC3 ^ (8'(k) * 8'h35);
   endfunction

   int checks = 0;
   int errors = 0;

   // bench-side slave model and monitors (written only here)
   int  take_idx = 0;
   int  rx_n = 0;
   int  acc_n = 0;
   int  done_n = 0;
   int  pre = 0, tail = 0, rc = 0;
   int  last_pre = 0, last_tail = 0, last_rises = 0;
   bit  seen_rise = 0;
   logic nss_q = 1'b1, sclk_q = 1'b0;
   logic [7:0] sreg = 8'h00;
   logic [7:0] rx_got [0:63];
   logic [7:0] slv_got [0:15];

   // task-side bases (written only by tasks)
   int tx_base = 0;

   assign tx_data = m_byte(take_idx - tx_base);
   assign miso    = s_byte(rc / 8)[7 - (rc % 8)];

   always @(negedge clk) begin
      if (done) done_n++;
      if (rx_valid && rx_n < 64) begin rx_got[rx_n] = rx_data; rx_n++; end
      if (tx_take) take_idx++;
      if (nss_oe && !nss_o) begin
         if (nss_q) begin
            acc_n++; pre = 0; tail = 0; rc = 0; seen_rise = 0;
         end
         if (sclk && !sclk_q) begin
            sreg = {sreg[6:0], mosi};
            if (rc % 8 == 7 && rc / 8 < 16) slv_got[rc / 8] = sreg;
            rc++;
            seen_rise = 1;
         end
         if (!sclk) begin
            if (!seen_rise) pre++;
            else tail++;
         end else begin
            tail = 0;
         end
      end else if (!nss_q) begin
         last_pre = pre; last_tail = tail; last_rises = rc;
      end
      nss_q  = nss_oe ? nss_o : 1'b1;
      sclk_q = sclk;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_done(input int target, input string req);
      int n = 0;
      while (done_n < target && n < 3000) begin @(negedge clk); n++; end
      check(done_n >= target, req, done_n, target);
      cycles(2);
   endtask

   task automatic pulse_host();
      tx_base = take_idx;
      host_start = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
   endtask

   task automatic check_data(input int bytes, input int rx_base, input string req);
      for (int k = 0; k < bytes; k++) begin
         check(rx_got[rx_base + k] == s_byte(k), req, int'(rx_got[rx_base + k]), int'(s_byte(k)));
         check(slv_got[k] == m_byte(k), req, int'(slv_got[k]), int'(m_byte(k)));
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; bus_enable = 1'b0;
      cycles(3);
      check(!nss_oe && !mosi_oe, "R1 released in reset", {nss_oe, mosi_oe}, 0);
      check(!sclk && !busy, "R1 clock low idle in reset", {sclk, busy}, 0);
      rst_n = 1'b1; bus_enable = 1'b1;
      cycles(3);
      check(nss_oe && nss_o && mosi_oe, "R1 select driven high", {nss_oe, nss_o, mosi_oe}, 7);
      check(acc_n == 0 && !busy, "R1 no access after reset", acc_n, 0);
   endtask

   task automatic t_host(input int bytes, input bit sleep, input bit skip, input int t, input string req);
      int a0 = acc_n, d0 = done_n, r0 = rx_n;
      byte_count = 8'(bytes); slave_sleeping = sleep; skip_wait = skip;
      pulse_host();
      cycles(2);
      check(busy, "R10 busy during access", busy, 1);
      wait_done(d0 + 1, req);
      check(acc_n == a0 + 1, req, acc_n - a0, 1);
      check(last_pre == t + 1 + HALF, req, last_pre, t + 1 + HALF);
      check(last_rises == 8 * bytes, "R7 rising edges", last_rises, 8 * bytes);
      if (bytes > 0) check(last_tail == HALF, "R8 select hold", last_tail, HALF);
      check(rx_n == r0 + bytes, "R7 rx count", rx_n - r0, bytes);
      check_data(bytes, r0, "R7 data");
      slave_sleeping = 1'b0; skip_wait = 1'b0;
   endtask

   task automatic t_slave();
      int a0 = acc_n, d0 = done_n, r0 = rx_n;
      byte_count = 8'd2; skip_wait = 1'b1;   // skip must not apply to slave path
      tx_base = take_idx;
      slave_irq = 1'b1;
      wait_done(d0 + 1, "R5 slave access done");
      check(acc_n == a0 + 1, "R5 one access", acc_n - a0, 1);
      check(last_pre == T1 + 1 + HALF, "R5 wait from request", last_pre, T1 + 1 + HALF);
      check_data(2, r0, "R5 data");
      cycles(150);
      check(acc_n == a0 + 1, "R5 level held gives no access", acc_n - a0, 1);
      slave_irq = 1'b0; skip_wait = 1'b0;
      cycles(10);
   endtask

   task automatic t_simul();
      int a0 = acc_n, d0 = done_n;
      byte_count = 8'd1; skip_wait = 1'b1;
      tx_base = take_idx;
      host_start = 1'b1; slave_irq = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
      wait_done(d0 + 1, "R6 merged access done");
      cycles(100);
      check(acc_n == a0 + 1, "R6 single access", acc_n - a0, 1);
      check(last_pre == 1 + HALF, "R6 host rules apply", last_pre, 1 + HALF);
      slave_irq = 1'b0; skip_wait = 1'b0;
      cycles(10);
   endtask

   task automatic t_queue();
      int a0 = acc_n, d0 = done_n;
      byte_count = 8'd2;
      pulse_host();
      cycles(20);
      check(busy, "R10 busy when second start", busy, 1);
      host_start = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
      wait_done(d0 + 1, "R10 first done");
      tx_base = take_idx;
      wait_done(d0 + 2, "R10 queued done");
      check(acc_n == a0 + 2, "R10 two accesses", acc_n - a0, 2);
      check(done_n == d0 + 2, "R10 done single cycle", done_n - d0, 2);
      check(!busy, "R10 idle after queue", busy, 0);
   endtask

   task automatic t_zero();
      int a0 = acc_n, d0 = done_n;
      byte_count = 8'd0;
      pulse_host();
      wait_done(d0 + 1, "R11 zero bytes done");
      check(acc_n == a0 + 1, "R11 select pulse", acc_n - a0, 1);
      check(last_rises == 0, "R11 no clock", last_rises, 0);
   endtask

   task automatic t_off();
      int a0 = acc_n, d0 = done_n;
      byte_count = 8'd2;
      pulse_host();
      cycles(5);
      bus_enable = 1'b0;
      wait_done(d0 + 1, "R9 access completes");
      check(last_rises == 16, "R9 full access before off", last_rises, 16);
      cycles(2);
      check(!nss_oe && !mosi_oe && !sclk, "R9 lines released", {nss_oe, mosi_oe, sclk}, 0);
      host_start = 1'b1;
      @(negedge clk);
      host_start = 1'b0;
      slave_irq = 1'b1;
      cycles(100);
      check(acc_n == a0 + 1 && !nss_oe, "R9 requests ignored off", acc_n - a0, 1);
      slave_irq = 1'b0;
      cycles(5);
      bus_enable = 1'b1;
      cycles(60);
      check(nss_oe && nss_o && acc_n == a0 + 1, "R9 reenabled without access", acc_n - a0, 1);
   endtask

   initial begin
      t_reset();
      t_host(3, 1'b0, 1'b0, T1, "R2 host access");
      t_host(2, 1'b1, 1'b0, T3, "R3 resume wait");
      t_host(1, 1'b0, 1'b1, 0,  "R4 skip wait");
      t_slave();
      t_simul();
      t_queue();
      t_zero();
      t_off();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1ms;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule